// File: doc/BRIEF.md
# Pipeline Destination-Tag Checker

This block watches a five-stage in-order pipeline for injected faults that corrupt the destination register index as it travels from decode to write-back. Each time a register-writing instruction is decoded, its 4-bit destination index is pushed into a small circular queue. When that instruction retires at write-back, the oldest queued index is popped and compared with the index the pipeline registers delivered. The verdict of each check is held in a registered validity flag, and any failure also raises a one-cycle error pulse.

Only instructions that write a register take part: the pipeline asserts the decode strobe and the write-back strobe for those instructions only. A flush input empties the queue when the pipeline discards in-flight instructions. Misuse of the queue, such as a pop with nothing queued or a push with all slots in use, counts as a failed check, because in a correct pipeline neither can happen.

Top module: `dest_tag_checker`

## Requirements
- R1: A clock edge with `dec_vld_i` high (no flush, queue not blocked) appends `dec_idx_i` to the tail of the queue; the queue holds up to DEPTH = 8 indices in arrival order.
- R2: A clock edge with `wb_vld_i` high and a non-empty queue removes the oldest index; if it equals `wb_idx_i`, then after that edge `valid_o` = 1 and `err_o` = 0.
- R3: If the removed index differs from `wb_idx_i`, then after that edge `valid_o` = 0 and `err_o` = 1 for exactly one cycle; the entry is consumed all the same.
- R4: An edge with no write-back strobe and no rejected push leaves `valid_o` unchanged and drives `err_o` to 0.
- R5: `wb_vld_i` with an empty queue (occupancy counted before the edge) gives `valid_o` = 0 and an `err_o` pulse and removes nothing; a push in that same cycle is still accepted.
- R6: `dec_vld_i` while 8 indices are held and no successful pop occurs in the same cycle drops the index, gives `valid_o` = 0 and an `err_o` pulse.
- R7: A push and a pop at the same edge are both performed, also with a full queue, where the pop frees the slot; occupancy is then unchanged.
- R8: `flush_i` high at an edge empties the queue and gives `valid_o` = 1, `err_o` = 0, overriding both strobes.
- R9: After reset the queue is empty, `valid_o` = 1 and `err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Pipeline flush: empty the queue, restore validity |
| dec_vld_i | input | 1 | A register-writing instruction is in decode |
| dec_idx_i | input | 4 | Destination index seen at decode |
| wb_vld_i | input | 1 | A register-writing instruction is in write-back |
| wb_idx_i | input | 4 | Destination index carried to write-back |
| valid_o | output | 1 | Result of the most recent check (1 = good) |
| err_o | output | 1 | One-cycle pulse on any failed check |

## Verification
Decode pushes and write-back pops fall in the same cycle in any steady pipeline, and the sharpest case is a full queue, where the pop must make room for the push and both take the same slot. The bench provokes this by filling all eight slots and then driving both strobes together, with matching and corrupted write-back indices, and by long random runs where the two strobes often coincide. A behavioural queue model in the bench predicts `valid_o` and `err_o` every cycle and the observed outputs are compared against it, so a lost push or a wrong slot read shows up as a later mismatch.

// File: rtl/dtc_pkg.sv
package dtc_pkg;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_PASS  = 2'd1,
        EV_FAIL  = 2'd2,
        EV_FLUSH = 2'd3
    } check_ev_e;

    typedef struct packed {
        logic valid;
        logic err;
    } verdict_t;

endpackage

// File: rtl/dtc_ptr.sv
module dtc_ptr #(
    parameter int DEPTH = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_i,
    input  logic          enq_req_i,
    input  logic          deq_req_i,
    output logic [AW-1:0] wr_ptr_o,
    output logic [AW-1:0] rd_ptr_o,
    output logic          enq_ok_o,
    output logic          deq_ok_o,
    output logic          ovf_o,
    output logic          unf_o,
    output logic          full_o
);

    localparam logic [AW:0]   FULL_CNT = (AW+1)'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    typedef struct packed {
        logic [AW-1:0] wr;
        logic [AW-1:0] rd;
        logic [AW:0]   cnt;
    } ptr_state_t;

    ptr_state_t st_d, st_q;
    logic empty, full, enq_ok, deq_ok;

    always_comb begin
        empty  = (st_q.cnt == '0);
        full   = (st_q.cnt == FULL_CNT);
        deq_ok = deq_req_i && !empty;
        enq_ok = enq_req_i && (!full || deq_ok);

        st_d = st_q;
        if (flush_i) begin
            st_d = '0;
        end else begin
            if (enq_ok)
                st_d.wr = (st_q.wr == LAST_PTR) ? '0 : st_q.wr + 1'b1;
            if (deq_ok)
                st_d.rd = (st_q.rd == LAST_PTR) ? '0 : st_q.rd + 1'b1;
            st_d.cnt = st_q.cnt + {{AW{1'b0}}, enq_ok} - {{AW{1'b0}}, deq_ok};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_ptr_o = st_q.wr;
    assign rd_ptr_o = st_q.rd;
    assign enq_ok_o = enq_ok;
    assign deq_ok_o = deq_ok;
    assign ovf_o    = enq_req_i && !enq_ok;
    assign unf_o    = deq_req_i && empty;
    assign full_o   = full;

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= FULL_CNT); // R1

    AST_PTR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        ((int'(st_q.wr) - int'(st_q.rd) + DEPTH) % DEPTH) == (int'(st_q.cnt) % DEPTH)); // R7

endmodule

// File: rtl/dtc_store.sv
module dtc_store #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 4,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [AW-1:0]    waddr_i,
    input  logic [IDX_W-1:0] wdata_i,
    input  logic [AW-1:0]    raddr_i,
    output logic [IDX_W-1:0] rdata_o
);

    logic [IDX_W-1:0] slot_d [DEPTH];
    logic [IDX_W-1:0] slot_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_comb begin
            slot_d[g] = slot_q[g];
            if (we_i && (waddr_i == AW'(g)))
                slot_d[g] = wdata_i;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[g] <= '0;
            else        slot_q[g] <= slot_d[g];
        end
    end

    assign rdata_o = slot_q[raddr_i];

endmodule

// File: rtl/dtc_verdict.sv
module dtc_verdict
    import dtc_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             deq_req_i,
    input  logic             deq_ok_i,
    input  logic             ovf_i,
    input  logic             unf_i,
    input  logic [IDX_W-1:0] exp_idx_i,
    input  logic [IDX_W-1:0] got_idx_i,
    output logic             valid_o,
    output logic             err_o
);

    verdict_t  vd_d, vd_q;
    check_ev_e ev;
    logic      mismatch;

    always_comb begin
        mismatch = deq_ok_i && (exp_idx_i != got_idx_i);
        if (flush_i)
            ev = EV_FLUSH;
        else if (ovf_i || unf_i || mismatch)
            ev = EV_FAIL;
        else if (deq_req_i)
            ev = EV_PASS;
        else
            ev = EV_NONE;

        vd_d = vd_q;
        unique case (ev)
            EV_FLUSH: vd_d = '{valid: 1'b1, err: 1'b0};
            EV_FAIL:  vd_d = '{valid: 1'b0, err: 1'b1};
            EV_PASS:  vd_d = '{valid: 1'b1, err: 1'b0};
            default:  vd_d.err = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vd_q <= '{valid: 1'b1, err: 1'b0};
        else        vd_q <= vd_d;
    end

    assign valid_o = vd_q.valid;
    assign err_o   = vd_q.err;

    AST_MISMATCH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && deq_ok_i && (exp_idx_i != got_idx_i)) |=> (err_o && !valid_o)); // R3

    AST_EMPTY_POP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && unf_i) |=> (err_o && !valid_o)); // R5

endmodule

// File: rtl/dest_tag_checker.sv
module dest_tag_checker #(
    parameter int DEPTH = 8,
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             dec_vld_i,
    input  logic [IDX_W-1:0] dec_idx_i,
    input  logic             wb_vld_i,
    input  logic [IDX_W-1:0] wb_idx_i,
    output logic             valid_o,
    output logic             err_o
);

    localparam int AW = $clog2(DEPTH);

    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic             enq_ok, deq_ok, ovf, unf, full;
    logic [IDX_W-1:0] head_idx;

    dtc_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush_i),
        .enq_req_i (dec_vld_i),
        .deq_req_i (wb_vld_i),
        .wr_ptr_o  (wr_ptr),
        .rd_ptr_o  (rd_ptr),
        .enq_ok_o  (enq_ok),
        .deq_ok_o  (deq_ok),
        .ovf_o     (ovf),
        .unf_o     (unf),
        .full_o    (full)
    );

    dtc_store #(.DEPTH(DEPTH), .IDX_W(IDX_W), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (enq_ok && !flush_i),
        .waddr_i (wr_ptr),
        .wdata_i (dec_idx_i),
        .raddr_i (rd_ptr),
        .rdata_o (head_idx)
    );

    dtc_verdict #(.IDX_W(IDX_W)) u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush_i),
        .deq_req_i (wb_vld_i),
        .deq_ok_i  (deq_ok),
        .ovf_i     (ovf),
        .unf_i     (unf),
        .exp_idx_i (head_idx),
        .got_idx_i (wb_idx_i),
        .valid_o   (valid_o),
        .err_o     (err_o)
    );

    AST_FLUSH_RECOVER: assert property (@(posedge clk) disable iff (!rst_n)
        flush_i |=> (valid_o && !err_o)); // R8

    AST_ERR_DROPS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> !valid_o); // R3

    AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !wb_vld_i && !(dec_vld_i && full)) |=> ($stable(valid_o) && !err_o)); // R4

    AST_FULL_PUSH_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_i && !wb_vld_i && dec_vld_i && full) |=> (err_o && !valid_o)); // R6

endmodule

// File: tb/tb_dest_tag_checker.sv
module tb_dest_tag_checker;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       flush_i = 1'b0;
    logic       dec_vld_i = 1'b0;
    logic [3:0] dec_idx_i = '0;
    logic       wb_vld_i = 1'b0;
    logic [3:0] wb_idx_i = '0;
    logic       valid_o, err_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    int m_q[$];
    bit m_valid = 1'b1;
    bit m_err   = 1'b0;

    always #2 clk = ~clk;

    dest_tag_checker dut (
        .clk(clk), .rst_n(rst_n), .flush_i(flush_i),
        .dec_vld_i(dec_vld_i), .dec_idx_i(dec_idx_i),
        .wb_vld_i(wb_vld_i), .wb_idx_i(wb_idx_i),
        .valid_o(valid_o), .err_o(err_o)
    );

    task automatic check(string tag);
        n_cmp++;
        if (valid_o !== m_valid || err_o !== m_err) begin
            n_bad++;
            $display("FAIL %s t=%0t valid/err actual=%b%b expected=%b%b",
                     tag, $time, valid_o, err_o, m_valid, m_err);
        end
    endtask

    // one clock: drive at negedge, model the edge, compare after it
    task automatic step(bit dv, int di, bit wv, int wi, bit fl);
        string tag;
        bit unf, ovf, deq_ok, bad;
        @(negedge clk);
        dec_vld_i = dv; dec_idx_i = 4'(di);
        wb_vld_i  = wv; wb_idx_i  = 4'(wi);
        flush_i   = fl;
        bad = 1'b0;
        if (fl) begin
            m_q.delete(); m_valid = 1'b1; m_err = 1'b0; tag = "R8";
        end else begin
            unf    = wv && (m_q.size() == 0);
            deq_ok = wv && (m_q.size() > 0);
            ovf    = dv && (m_q.size() == 8) && !deq_ok;
            if (deq_ok) bad = (m_q.pop_front() != wi);
            if (dv && !ovf) m_q.push_back(di);
            if (wv || ovf) begin
                bad = bad | unf | ovf;
                m_valid = !bad; m_err = bad;
            end else begin
                m_err = 1'b0;
            end
            if (unf)               tag = "R5";
            else if (ovf)          tag = "R6";
            else if (dv && wv)     tag = "R7";
            else if (wv && bad)    tag = "R3";
            else if (wv)           tag = "R2";
            else if (dv)           tag = "R1";
            else                   tag = "R4";
        end
        @(posedge clk);
        #1;
        check(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #200000;
        n_bad++;
        $display("FAIL watchdog expired, actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R9");
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("R9");

        // R1/R2: in-order pushes and matching pops
        for (int i = 0; i < 4; i++) step(1, i + 3, 0, 0, 0);
        for (int i = 0; i < 4; i++) step(0, 0, 1, i + 3, 0);
        step(0, 0, 0, 0, 0);                           // R4 idle after pass

        // R3: corrupted write-back index, then recovery
        step(1, 9, 0, 0, 0);
        step(1, 10, 0, 0, 0);
        step(0, 0, 1, 5, 0);                           // mismatch
        step(0, 0, 0, 0, 0);                           // R4 holds low
        step(1, 2, 0, 0, 0);                           // R4 push keeps low
        step(0, 0, 1, 10, 0);                          // entry consumed, next matches
        step(0, 0, 1, 2, 0);

        // R5: pop from empty, with and without a push
        step(0, 0, 1, 1, 0);
        step(1, 7, 1, 7, 0);
        step(0, 0, 1, 7, 0);                           // pushed index was kept

        // R6: fill eight slots, then overflow
        for (int i = 0; i < 8; i++) step(1, 15 - i, 0, 0, 0);
        step(1, 4, 0, 0, 0);                           // dropped
        // R7: full queue, push and pop together
        step(1, 6, 1, 15, 0);
        step(1, 1, 1, 3, 0);                           // mismatch while full
        for (int i = 0; i < 6; i++) step(0, 0, 1, 13 - i, 0);
        step(0, 0, 1, 6, 0);
        step(0, 0, 1, 1, 0);
        step(0, 0, 1, 0, 0);                           // now empty

        // R8: flush overrides strobes
        step(1, 3, 0, 0, 0);
        step(1, 3, 1, 9, 1);
        step(0, 0, 1, 3, 0);                           // queue was emptied

        // pipeline-like traffic: pop four cycles after push, with faults
        begin
            int lag[$];
            for (int c = 0; c < 400; c++) begin
                bit dv, wv;
                int di, wi;
                dv = ($urandom_range(0, 3) != 0);
                di = $urandom_range(0, 15);
                wv = (lag.size() >= 4) || ($urandom_range(0, 9) == 0);
                wi = (lag.size() > 0) ? lag[0] : $urandom_range(0, 15);
                if ($urandom_range(0, 19) == 0) wi = (wi + 1) % 16;
                if (wv && lag.size() > 0) void'(lag.pop_front());
                if (dv) lag.push_back(di);
                step(dv, di, wv, wi, $urandom_range(0, 99) == 0);
                if (flush_i) lag.delete();
            end
        end

        // fully random mix
        for (int c = 0; c < 600; c++)
            step($urandom_range(0, 1), $urandom_range(0, 15),
                 $urandom_range(0, 1), $urandom_range(0, 3),
                 $urandom_range(0, 63) == 0);

        finish_run();
    end

endmodule